// File: doc/BRIEF.md
# Multi-Cycle Restoring Integer Divider

This block divides an unsigned dividend of twice the base width by an unsigned divisor of the base width. It returns a quotient and a remainder, both of the base width. The base width K is a parameter. The default is 4, which gives an 8-by-4 division, and the same code scales up to 64-by-32. A request is a one-cycle `start` pulse given while `ready` is high. The block samples both operands on that edge. The result comes back with a one-cycle `done` pulse, and the outputs hold until the next request is accepted.

A working register holds the partial remainder and starts out loaded with the full dividend. Each step shifts this register left by one. A ripple subtractor then always forms a trial difference between the upper half of the shifted value and the divisor. A digit selector looks at the subtractor's carry-out and at the bit shifted out of the register. If either is set, the quotient bit is 1 and the difference replaces the upper half. Otherwise the quotient bit is 0 and the shifted value is kept as it is. Quotient bits come out most significant first and shift into a quotient register. After exactly K steps the upper half of the working register is the remainder.

Two requests are finished on the edge that accepts them, without iterating. A zero divisor is one. A dividend whose upper half is not below the divisor is the other, because its quotient cannot fit in K bits.

Top module: `seq_divider`

## Requirements
- R1: While reset is high, and in the first cycle after it, `ready` is 1 and `done`, `div_zero`, `ovf`, `quotient` and `remainder` are all 0.
- R2: A request is accepted only on an edge where `start` and `ready` are both 1. During a division `ready` is 0, and a `start` pulse given while `ready` is 0 has no effect on the result.
- R3: When the divisor D is non-zero and the dividend's upper half is below D, `quotient` equals floor(N/D) and `remainder` equals N mod D. `done` is high in the cycle after the K+1-th rising edge, counting the accepting edge as the first.
- R4: For every normal completion, `remainder` is strictly less than the divisor that was sampled.
- R5: When the divisor is 0, `done` and `div_zero` are high in the cycle after the accepting edge. `quotient` is then all ones and `remainder` equals the lower K bits of the dividend.
- R6: When the divisor is non-zero and the dividend's upper K bits are greater than or equal to it, `done` and `ovf` are high in the cycle after the accepting edge. `quotient` is then all ones and `remainder` equals the dividend's upper K bits.
- R7: `done` is high for exactly one cycle. `quotient`, `remainder` and both flags keep their values until the next request is accepted.
- R8: `div_zero` and `ovf` are never high together. A zero divisor always reports `div_zero`, even though its upper-half comparison would also indicate overflow.
- R9: Results are correct when the bit shifted out of the partial remainder is 1. For example, with K=4, 231/15 gives quotient 15 and remainder 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request pulse, taken when `ready` is 1 |
| dividend | input | 2K | Unsigned dividend |
| divisor | input | K | Unsigned divisor |
| ready | output | 1 | Idle and able to accept a request |
| done | output | 1 | One-cycle completion pulse |
| quotient | output | K | Registered quotient |
| remainder | output | K | Registered remainder |
| div_zero | output | 1 | Divisor was zero |
| ovf | output | 1 | Quotient would not fit in K bits |

## Verification
The bench drives each request at a falling edge and then counts rising edges until it sees `done` at a later falling edge. It expects K+1 edges for an iterated division. It expects one edge for a zero divisor or an overflow, because those are settled on the accepting edge. Each result is compared in the cycle where `done` is high. One falling edge later the bench checks that `done` has dropped and that the results have not changed. For the busy-start case, the competing pulse is placed two edges after acceptance, and the final result is checked against the first request's operands.

// File: rtl/div_pkg.sv
package div_pkg;
  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } div_state_t;
endpackage

// File: rtl/div_trial_sub.sv
// Ripple subtractor: a - b computed as a + ~b + 1.
// cout = 1 means no borrow occurred.
module div_trial_sub #(
  parameter int K = 4
) (
  input  logic [K-1:0] a,
  input  logic [K-1:0] b,
  output logic [K-1:0] diff,
  output logic         cout
);
  logic [K:0] c;
  assign c[0] = 1'b1;

  for (genvar i = 0; i < K; i++) begin : g_cell
    logic nb;
    assign nb      = ~b[i];
    assign diff[i] = a[i] ^ nb ^ c[i];
    assign c[i+1]  = (a[i] & nb) | ((a[i] ^ nb) & c[i]);
  end

  assign cout = c[K];
endmodule

// File: rtl/div_digit_sel.sv
// Quotient-digit selector plus the restore mux.
module div_digit_sel #(
  parameter int K = 4
) (
  input  logic         shifted_out,
  input  logic         carry_out,
  input  logic [K-1:0] trial_diff,
  input  logic [K-1:0] kept_upper,
  output logic         qbit,
  output logic [K-1:0] next_upper
);
  always_comb begin
    qbit       = shifted_out | carry_out;
    next_upper = qbit ? trial_diff : kept_upper;
  end
endmodule

// File: rtl/div_step_count.sv
module div_step_count #(
  parameter int K = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic en,
  output logic last
);
  localparam int CW = $clog2(K + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clear) cnt <= '0;
    else if (en)      cnt <= cnt + CW'(1);
  end

  assign last = (cnt == CW'(K - 1));
endmodule

// File: rtl/seq_divider.sv
module seq_divider
  import div_pkg::*;
#(
  parameter int K = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic [2*K-1:0] dividend,
  input  logic [K-1:0]   divisor,
  output logic           ready,
  output logic           done,
  output logic [K-1:0]   quotient,
  output logic [K-1:0]   remainder,
  output logic           div_zero,
  output logic           ovf
);
  localparam int W = 2 * K;

  div_state_t   state;
  logic [W-1:0] pr;
  logic [K-1:0] qr;
  logic [K-1:0] dvs_q;

  logic         accept;
  logic         last;
  logic         msb_out;
  logic [K-1:0] upper_sh;
  logic [K-1:0] trial_diff;
  logic         trial_cout;
  logic         qbit;
  logic [K-1:0] next_upper;

  assign ready    = (state == ST_IDLE);
  assign accept   = start && ready;
  assign msb_out  = pr[W-1];
  assign upper_sh = pr[W-2:K-1];

  div_trial_sub #(.K(K)) u_sub (
    .a    (upper_sh),
    .b    (dvs_q),
    .diff (trial_diff),
    .cout (trial_cout)
  );

  div_digit_sel #(.K(K)) u_sel (
    .shifted_out (msb_out),
    .carry_out   (trial_cout),
    .trial_diff  (trial_diff),
    .kept_upper  (upper_sh),
    .qbit        (qbit),
    .next_upper  (next_upper)
  );

  div_step_count #(.K(K)) u_cnt (
    .clk   (clk),
    .rst   (rst),
    .clear (accept),
    .en    (state == ST_RUN),
    .last  (last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      pr        <= '0;
      qr        <= '0;
      dvs_q     <= '0;
      done      <= 1'b0;
      quotient  <= '0;
      remainder <= '0;
      div_zero  <= 1'b0;
      ovf       <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            dvs_q <= divisor;
            if (divisor == '0) begin
              done      <= 1'b1;
              div_zero  <= 1'b1;
              ovf       <= 1'b0;
              quotient  <= '1;
              remainder <= dividend[K-1:0];
            end else if (dividend[W-1:K] >= divisor) begin
              done      <= 1'b1;
              div_zero  <= 1'b0;
              ovf       <= 1'b1;
              quotient  <= '1;
              remainder <= dividend[W-1:K];
            end else begin
              pr       <= dividend;
              qr       <= '0;
              div_zero <= 1'b0;
              ovf      <= 1'b0;
              state    <= ST_RUN;
            end
          end
        end
        ST_RUN: begin
          pr <= {next_upper, pr[K-2:0], 1'b0};
          qr <= {qr[K-2:0], qbit};
          if (last) begin
            state     <= ST_IDLE;
            done      <= 1'b1;
            quotient  <= {qr[K-2:0], qbit};
            remainder <= next_upper;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/div_checker.sv
module div_checker #(
  parameter int K = 4
) (
  input logic         clk,
  input logic         rst,
  input logic         start,
  input logic         ready,
  input logic         done,
  input logic [K-1:0] quotient,
  input logic [K-1:0] remainder,
  input logic         div_zero,
  input logic         ovf,
  input logic [K-1:0] dvs_q
);
  // R1
  reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (ready && !done && !div_zero && !ovf));

  // R2
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (rst)
    (start && ready) |=> (done || !ready));

  // R4
  rem_below_div_chk: assert property (@(posedge clk) disable iff (rst)
    (done && !div_zero && !ovf) |-> (remainder < dvs_q));

  // R5
  zero_quot_chk: assert property (@(posedge clk) disable iff (rst)
    (done && div_zero) |-> (quotient == {K{1'b1}}));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R7
  hold_result_chk: assert property (@(posedge clk) disable iff (rst)
    (!done && !$past(start && ready)) |-> ($stable(quotient) && $stable(remainder)));

  // R8
  flag_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(div_zero && ovf));
endmodule

bind seq_divider div_checker #(.K(K)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .start     (start),
  .ready     (ready),
  .done      (done),
  .quotient  (quotient),
  .remainder (remainder),
  .div_zero  (div_zero),
  .ovf       (ovf),
  .dvs_q     (dvs_q)
);

// File: tb/seq_divider_test.sv
`timescale 1ns/1ps
module seq_divider_test;
  localparam int K = 4;
  localparam int W = 2 * K;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           start = 1'b0;
  logic [W-1:0]   dividend = '0;
  logic [K-1:0]   divisor = '0;
  logic           ready, done, div_zero, ovf;
  logic [K-1:0]   quotient, remainder;

  int vectors = 0;
  int fails   = 0;

  always #4 clk = ~clk;

  seq_divider #(.K(K)) uut (
    .clk(clk), .rst(rst), .start(start), .dividend(dividend), .divisor(divisor),
    .ready(ready), .done(done), .quotient(quotient), .remainder(remainder),
    .div_zero(div_zero), .ovf(ovf)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic void model(input logic [W-1:0] n, input logic [K-1:0] d,
                                output logic [K-1:0] q, output logic [K-1:0] r,
                                output logic dz, output logic ov, output int lat);
    dz = 1'b0; ov = 1'b0;
    if (d == 0) begin
      q = '1; r = n[K-1:0]; dz = 1'b1; lat = 1;
    end else if (n[W-1:K] >= d) begin
      q = '1; r = n[W-1:K]; ov = 1'b1; lat = 1;
    end else begin
      q = K'(n / W'(d)); r = K'(n % W'(d)); lat = K + 1;
    end
  endfunction

  task automatic run(input logic [W-1:0] n, input logic [K-1:0] d,
                     input string req, input bit busy_poke);
    logic [K-1:0] eq, er;
    logic edz, eov;
    int elat, edges;
    model(n, d, eq, er, edz, eov, elat);
    while (!ready) @(negedge clk);
    dividend = n; divisor = d; start = 1'b1;
    edges = 0;
    forever begin
      @(posedge clk);
      edges++;
      @(negedge clk);
      start = 1'b0;
      if (busy_poke && edges == 2) begin
        // R2: start while busy must be ignored
        chk("R2 ready low while busy", ready, 0);
        dividend = ~n; divisor = d ^ 1; start = 1'b1;
      end
      if (done || edges > 2 * K + 4) break;
    end
    start = 1'b0;
    chk({req, " latency"}, edges, elat);
    chk({req, " quotient"}, quotient, eq);
    chk({req, " remainder"}, remainder, er);
    chk({req, " div_zero"}, div_zero, edz);
    chk({req, " ovf"}, ovf, eov);
    @(negedge clk);
    // R7: one-cycle done, results held
    chk("R7 done pulse", done, 0);
    chk("R7 quotient hold", quotient, eq);
    chk("R7 remainder hold", remainder, er);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    logic [K-1:0] d, u;
    logic [W-1:0] n;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 ready", ready, 1);
    chk("R1 done", done, 0);
    chk("R1 quotient", quotient, 0);
    chk("R1 remainder", remainder, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 flags after reset", {div_zero, ovf}, 0);

    run(8'd90,  4'd7,  "R3 90/7", 1'b0);
    run(8'd231, 4'd15, "R9 231/15", 1'b0);
    run(8'd239, 4'd15, "R9 239/15", 1'b0);
    run(8'd0,   4'd1,  "R3 0/1", 1'b0);
    run(8'd55,  4'd0,  "R5 55/0", 1'b0);
    run(8'h12,  4'd0,  "R8 zero priority", 1'b0);
    run(8'hF0,  4'd3,  "R6 240/3", 1'b0);
    run(8'h30,  4'd3,  "R6 equal upper", 1'b0);
    run(8'd200, 4'd13, "R2 busy start", 1'b1);

    for (int i = 0; i < 300; i++) begin
      d = K'($urandom);
      if (i % 4 != 0) begin
        if (d == 0) d = 1;
        u = K'($urandom % d);
        n = {u, K'($urandom)};
        run(n, d, "R3 random", 1'b0);
      end else begin
        n = W'($urandom);
        run(n, d, "R3 R5 R6 random", 1'b0);
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule